// File: doc/BRIEF.md
# Multi-Channel Event Timer

This peripheral holds one 64-bit up-counter and an array of comparator channels (twelve by default). Software reaches them over a 32-bit word-addressed register bus. The counter advances by one on each clock where both its run bit and the external count tick are high. Each channel is armed with a relative period. When it is armed, it computes its own absolute target from the counter and raises a dedicated level interrupt when the counter reaches that target. This makes each channel fit for use as a private event timer for one processor core.

A channel fires once and disarms itself in one-shot mode. In circular mode it re-arms by adding its period to the previous target, so periodic events do not drift. Reading back a channel's enable register shows the armed state only after a fixed synchronizer lag. Software is expected to poll that register until it matches the value written. Each event latches a status bit, which is cleared by writing one. The interrupt line is that bit masked by a per-channel interrupt enable.

Top module: `event_timer_array`

## Requirements
- R1: After reset every register reads 0, the counter is stopped at 0 and every interrupt output is low.
- R2: Bit 0 of the word at 0x100 is the counter run bit. While it is 1 the counter adds 1 on each clock with `cnt_tick` high, and otherwise it holds. Its low word reads at 0x110 and its high word at 0x114.
- R3: A request is taken on every clock with `req_valid` high (`req_ready` stays 1). `rsp_valid` is high exactly one clock later. For a read, `rsp_rdata` carries the register value from before that edge. For a write, and whenever `rsp_valid` is low, `rsp_rdata` is 0. Write data takes effect at the accepting edge.
- R4: Channel i occupies base 0x200 + i*0x100 with these word offsets: 0x00 target low (read-only), 0x04 target high (read-only), 0x08 mode, 0x0C period, 0x10 enable, 0x14 interrupt enable, 0x18 status. Mode, enable, interrupt enable and status all use bit 0.
- R5: Writing 1 to enable arms the channel and loads target = counter value before the accepting edge + period.
- R6: The enable readback shows the internal armed state delayed by EN_DELAY clocks (4 by default). After an arming write accepted at edge E, reads accepted at edges E+1 to E+4 return 0 and a read at E+5 returns 1.
- R7: An event occurs on a clock where the channel is armed, the counter runs, `cnt_tick` is high and the counter equals the target. The status bit is then set at that edge.
- R8: With mode 0 (one-shot), an event disarms the channel and leaves its target unchanged. The enable readback returns to 0 after the lag.
- R9: With mode 1 (circular), an event advances the target by the period and the channel stays armed, so events repeat.
- R10: Writing 1 to status clears it, and writing 0 has no effect. If an event and a clear fall on the same edge, the bit ends up set.
- R11: `irq[i]` is high exactly when channel i's status and interrupt enable (offset 0x14) are both 1.
- R12: Reads of unmapped offsets, including any address past the last channel, return 0. Writes to unmapped offsets and to the target words change nothing.
- R13: Channels are independent: events, status and interrupts of one channel do not disturb another.
- R14: Writing 0 to enable disarms the channel, and it then produces no events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address of the register word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one clock after a request |
| rsp_rdata | output | 32 | Read data |
| cnt_tick | input | 1 | Count enable for the counter |
| irq | output | NUM_CH (12) | Per-channel level interrupts |

## Verification
The embedded assertions check these properties on every clock:
- the counter steps or holds correctly;
- arming loads the target from the counter and the period;
- an event always sets status;
- one-shot events disarm the channel;
- circular events advance the target by exactly one period;
- the response strobe follows the request by one clock and the read data is zero when idle.

The scenarios are needed to show the properties that span many clocks or cross registers:
- the exact lag of the enable readback;
- interrupt masking and the status bit winning over a simultaneous clear;
- channel independence;
- silence after disarming;
- unmapped addresses reading zero.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int BUS_W = 32;

  localparam int OFS_RUN    = 'h100;
  localparam int OFS_CNT_LO = 'h110;
  localparam int OFS_CNT_HI = 'h114;
  localparam int CH_BASE_BLK = 2;  // channel 0 starts at block 0x200

  typedef enum logic [7:0] {
    SUB_TGT_LO = 8'h00,
    SUB_TGT_HI = 8'h04,
    SUB_MODE   = 8'h08,
    SUB_PERIOD = 8'h0C,
    SUB_ENABLE = 8'h10,
    SUB_IE     = 8'h14,
    SUB_STAT   = 8'h18
  } chan_sub_e;

  typedef struct packed {
    logic mode;
    logic period;
    logic enable;
    logic ie;
    logic stat;
  } chan_wr_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             tick,
  output logic             run,
  output logic [CNT_W-1:0] count
);
  logic             run_nx;
  logic [CNT_W-1:0] count_nx;

  always_comb begin
    run_nx   = run_wr ? run_wdata : run;
    count_nx = count;
    if (run && tick) count_nx = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      count <= '0;
    end else begin
      run   <= run_nx;
      count <= count_nx;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (count == $past(count) + CNT_W'(1)));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick) |=> $stable(count));
endmodule

// File: rtl/evt_enable_sync.sv
module evt_enable_sync #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic stg [DEPTH];
      for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic stg_nx;
        if (k == 0) begin : g_first
          assign stg_nx = d;
        end else begin : g_rest
          assign stg_nx = stg[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[k] <= 1'b0;
          else        stg[k] <= stg_nx;
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int PER_W    = 32,
  parameter int EN_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_wr_t         wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             cnt_step,
  output logic [CNT_W-1:0] target,
  output logic             mode,
  output logic [PER_W-1:0] period,
  output logic             en_rb,
  output logic             ie,
  output logic             stat,
  output logic             irq
);
  logic             armed, armed_nx;
  logic [CNT_W-1:0] target_nx;
  logic             mode_nx, ie_nx, stat_nx;
  logic [PER_W-1:0] period_nx;
  logic             hit;

  assign hit = armed && cnt_step && (count == target);

  always_comb begin
    mode_nx   = wr.mode   ? wdata[0] : mode;
    ie_nx     = wr.ie     ? wdata[0] : ie;
    period_nx = wr.period ? wdata[PER_W-1:0] : period;
    armed_nx  = armed;
    target_nx = target;
    if (hit) begin
      if (mode) target_nx = target + CNT_W'(period);
      else      armed_nx  = 1'b0;
    end
    if (wr.enable) begin
      armed_nx = wdata[0];
      if (wdata[0]) target_nx = count + CNT_W'(period);
    end
    stat_nx = stat;
    if (wr.stat && wdata[0]) stat_nx = 1'b0;
    if (hit)                 stat_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      target <= '0;
      mode   <= 1'b0;
      period <= '0;
      ie     <= 1'b0;
      stat   <= 1'b0;
    end else begin
      armed  <= armed_nx;
      target <= target_nx;
      mode   <= mode_nx;
      period <= period_nx;
      ie     <= ie_nx;
      stat   <= stat_nx;
    end
  end

  evt_enable_sync #(.DEPTH(EN_DELAY)) u_rb_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (armed),
    .q    (en_rb)
  );

  assign irq = stat & ie;

  assert_arm_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.enable && wdata[0]) |=>
      (armed && target == $past(count) + CNT_W'($past(period))));
  assert_hit_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat);
  assert_oneshot_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !mode && !wr.enable) |=> (!armed && $stable(target)));
  assert_circ_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode && !wr.enable) |=>
      (armed && target == $past(target) + CNT_W'($past(period))));
  assert_disarm_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.enable && !wdata[0]) |=> !armed);
endmodule

// File: rtl/event_timer_array.sv
module event_timer_array
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH   = 12,
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 64,
  parameter int PER_W    = 32,
  parameter int EN_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic              cnt_tick,
  output logic [NUM_CH-1:0] irq
);
  localparam int BLK_W = ADDR_W - 8;

  logic             acc, acc_wr;
  logic [BLK_W-1:0] blk, ch_idx;
  logic             in_chan;
  logic [7:0]       sub;

  assign req_ready = 1'b1;
  assign acc       = req_valid;
  assign acc_wr    = acc && req_write;
  assign blk       = req_addr[ADDR_W-1:8];
  assign sub       = req_addr[7:0];
  assign in_chan   = (blk >= BLK_W'(CH_BASE_BLK));
  assign ch_idx    = blk - BLK_W'(CH_BASE_BLK);

  // counter
  logic             run;
  logic [CNT_W-1:0] count;
  logic [63:0]      cnt64;

  evt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_wr   (acc_wr && req_addr == ADDR_W'(OFS_RUN)),
    .run_wdata(req_wdata[0]),
    .tick     (cnt_tick),
    .run      (run),
    .count    (count)
  );
  assign cnt64 = 64'(count);

  // channels
  chan_wr_t         ch_wr   [NUM_CH];
  logic [CNT_W-1:0] ch_tgt  [NUM_CH];
  logic [PER_W-1:0] ch_per  [NUM_CH];
  logic             ch_mode [NUM_CH];
  logic             ch_enrb [NUM_CH];
  logic             ch_ie   [NUM_CH];
  logic             ch_stat [NUM_CH];

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel = acc_wr && in_chan && (ch_idx == BLK_W'(i));
      always_comb begin
        ch_wr[i].mode   = sel && (sub == SUB_MODE);
        ch_wr[i].period = sel && (sub == SUB_PERIOD);
        ch_wr[i].enable = sel && (sub == SUB_ENABLE);
        ch_wr[i].ie     = sel && (sub == SUB_IE);
        ch_wr[i].stat   = sel && (sub == SUB_STAT);
      end
      evt_channel #(
        .CNT_W   (CNT_W),
        .PER_W   (PER_W),
        .EN_DELAY(EN_DELAY)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ch_wr[i]),
        .wdata   (req_wdata),
        .count   (count),
        .cnt_step(run && cnt_tick),
        .target  (ch_tgt[i]),
        .mode    (ch_mode[i]),
        .period  (ch_per[i]),
        .en_rb   (ch_enrb[i]),
        .ie      (ch_ie[i]),
        .stat    (ch_stat[i]),
        .irq     (irq[i])
      );
    end
  endgenerate

  // read mux
  logic [BUS_W-1:0] rd_val;
  always_comb begin
    logic [63:0] t64;
    rd_val = '0;
    t64    = '0;
    if (req_addr == ADDR_W'(OFS_RUN))    rd_val = BUS_W'(run);
    if (req_addr == ADDR_W'(OFS_CNT_LO)) rd_val = cnt64[31:0];
    if (req_addr == ADDR_W'(OFS_CNT_HI)) rd_val = cnt64[63:32];
    for (int c = 0; c < NUM_CH; c++) begin
      if (in_chan && ch_idx == BLK_W'(c)) begin
        t64 = 64'(ch_tgt[c]);
        case (sub)
          SUB_TGT_LO: rd_val = t64[31:0];
          SUB_TGT_HI: rd_val = t64[63:32];
          SUB_MODE:   rd_val = BUS_W'(ch_mode[c]);
          SUB_PERIOD: rd_val = BUS_W'(ch_per[c]);
          SUB_ENABLE: rd_val = BUS_W'(ch_enrb[c]);
          SUB_IE:     rd_val = BUS_W'(ch_ie[c]);
          SUB_STAT:   rd_val = BUS_W'(ch_stat[c]);
          default:    rd_val = '0;
        endcase
      end
    end
  end

  logic [BUS_W-1:0] rdata_nx;
  assign rdata_nx = (acc && !req_write) ? rd_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= rdata_nx;
    end
  end

  assert_rsp_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));
endmodule

// File: tb/tb_event_timer_array.sv
module tb_event_timer_array;
  localparam int NCH = 12;
  localparam int DLY = 4;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cnt_tick;
  logic [NCH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  event_timer_array dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cnt_tick(cnt_tick), .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [11:0] ch(int i, int sub);
    return 12'(32'h200 + i * 32'h100 + sub);
  endfunction

  // monitor: pop expected responses
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (rsp_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rsp_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    item_t it;
    it.exp = 0; it.tag = "R3 write response";
    sb.push_back(it);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_tick = 0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; cnt_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(32'(irq), 0, "R1 irq after reset");
    bus_rd(12'h100, 0, "R1 run bit");
    bus_rd(12'h110, 0, "R1 count low");
    bus_rd(12'h114, 0, "R1 count high");
    bus_rd(ch(0, 'h0C), 0, "R1 period");
    bus_rd(ch(5, 'h10), 0, "R1 enable rb");
    bus_rd(ch(11, 'h18), 0, "R1 status");

    // R2 counter
    bus_wr(12'h100, 1);
    bus_rd(12'h100, 1, "R2 run bit readback");
    bus_rd(12'h110, 0, "R2 no count without tick");
    ticks(5);
    bus_rd(12'h110, 5, "R2 count low after 5 ticks");
    bus_rd(12'h114, 0, "R2 count high");
    bus_wr(12'h100, 0);
    ticks(3);
    bus_rd(12'h110, 5, "R2 stopped counter holds");
    bus_wr(12'h100, 1);

    // R4 R5 R6 channel 0 one-shot
    bus_wr(ch(0, 'h0C), 20);
    bus_wr(ch(0, 'h08), 0);
    bus_wr(ch(0, 'h14), 1);
    bus_wr(ch(0, 'h10), 1);
    for (int k = 1; k <= DLY + 1; k++)
      bus_rd(ch(0, 'h10), (k > DLY) ? 1 : 0, $sformatf("R6 enable rb at E+%0d", k));
    bus_rd(ch(0, 'h00), 25, "R5 target low = 5+20");
    bus_rd(ch(0, 'h04), 0, "R4 target high");
    bus_rd(ch(0, 'h0C), 20, "R4 period readback");

    // R7 R8 one-shot event
    ticks(19);
    chk(32'(irq[0]), 0, "R7 no event before target");
    bus_rd(ch(0, 'h18), 0, "R7 status before target");
    ticks(2);
    chk(32'(irq[0]), 1, "R7 R11 irq after event");
    bus_rd(ch(0, 'h18), 1, "R7 status set");
    repeat (6) @(negedge clk);
    bus_rd(ch(0, 'h10), 0, "R8 one-shot disarmed");
    bus_rd(ch(0, 'h00), 25, "R8 target unchanged");

    // R10 clear
    bus_wr(ch(0, 'h18), 0);
    bus_rd(ch(0, 'h18), 1, "R10 write 0 keeps status");
    bus_wr(ch(0, 'h18), 1);
    chk(32'(irq[0]), 0, "R10 R11 irq cleared");
    bus_rd(ch(0, 'h18), 0, "R10 status cleared");

    // R9 R11 channel 1 circular, ie off
    bus_wr(ch(1, 'h0C), 16);
    bus_wr(ch(1, 'h08), 1);
    bus_wr(ch(1, 'h10), 1);
    bus_rd(ch(1, 'h00), 42, "R5 ch1 target = 26+16");
    ticks(17);
    chk(32'(irq[1]), 0, "R11 masked irq");
    bus_rd(ch(1, 'h18), 1, "R9 ch1 status");
    bus_rd(ch(1, 'h00), 58, "R9 target advanced");
    bus_rd(ch(1, 'h10), 1, "R9 stays armed");
    bus_wr(ch(1, 'h14), 1);
    chk(32'(irq[1]), 1, "R11 irq unmasked");
    bus_wr(ch(1, 'h18), 1);
    chk(32'(irq[1]), 0, "R11 irq after clear");
    ticks(16);
    bus_rd(ch(1, 'h18), 1, "R9 repeat event");
    bus_rd(ch(1, 'h00), 74, "R9 target advanced again");
    chk(32'(irq[0]), 0, "R13 ch0 untouched");
    bus_rd(ch(0, 'h18), 0, "R13 ch0 status");

    // R14 disarm
    bus_wr(ch(1, 'h18), 1);
    bus_wr(ch(1, 'h10), 0);
    ticks(20);
    bus_rd(ch(1, 'h18), 0, "R14 no event after disarm");
    bus_rd(ch(1, 'h00), 74, "R14 target frozen");
    chk(32'(irq[1]), 0, "R14 irq low");

    // R10 set wins over clear, channel 2
    bus_wr(ch(2, 'h0C), 15);
    bus_wr(ch(2, 'h14), 1);
    bus_wr(ch(2, 'h10), 1);
    ticks(15);
    bus_rd(ch(2, 'h18), 0, "R7 ch2 before target");
    cnt_tick = 1;
    bus_wr(ch(2, 'h18), 1);
    cnt_tick = 0;
    bus_rd(ch(2, 'h18), 1, "R10 event wins over clear");
    chk(32'(irq[2]), 1, "R13 ch2 irq");
    chk(32'(irq[1:0]), 0, "R13 other irqs low");
    bus_rd(12'h110, 95, "R2 count low final");

    // R12 unmapped
    bus_wr(12'h120, 32'hFFFF);
    bus_rd(12'h120, 0, "R12 unmapped global");
    bus_wr(ch(0, 'h00), 32'h1234);
    bus_rd(ch(0, 'h00), 25, "R12 target not writable");
    bus_rd(ch(11, 'h1C), 0, "R12 unmapped sub offset");
    bus_wr(12'hE10, 1);
    bus_rd(12'hE10, 0, "R12 beyond last channel");
    bus_rd(ch(11, 'h10), 0, "R12 ch11 enable untouched");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R3 missing responses actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule